// File: doc/BRIEF.md
# Triggered Receive Byte-Order Aligner

This block sits in a receive datapath right after the byte deserializer. Each cycle it accepts a two-lane parallel word of 16-bit symbols. The upper half is the MS lane and is the earlier symbol in transmit order. The lower half is the LS lane. After a deserializer the lane boundary may fall on the wrong symbol. User logic pulses a trigger, and the block then hunts for a programmed ordering symbol. If that symbol shows up in the MS lane, the block slips the stream by one symbol position. In unshifted operation it does this by inserting one programmed pad symbol, so that the ordering symbol comes out in the LS lane.

After a slip, the block keeps one symbol in a holding register. Each output word is then built from that held symbol and the MS symbol of the current input. The alignment flag rises on the output word that carries the decision. It stays high until the next trigger edge or reset. Output words, their valid strobe and the flag are all registered, one cycle after the input word.

Top module: `byte_order_aligner`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `aligned` are 0. After release the block runs unshifted, so the first valid word `{a,b}` comes out as `{a,b}` one cycle later.
- R2: Only a 0-to-1 change of `trig` starts a hunt. Holding `trig` high after a decision starts no new hunt, so a later ordering symbol neither changes the lane offset nor the output word.
- R3: In unshifted operation, a hunted valid word `{ORD,x}` (ORD in bits 31:16) gives the output `{PAD,ORD}`. The block then enters shifted operation with `x` held, and `aligned` is 1 on that output cycle.
- R4: In unshifted operation, a hunted valid word `{y,ORD}` with `y` not equal to ORD is passed out unchanged, with no pad, and `aligned` becomes 1.
- R5: In shifted operation, each valid input `{m,l}` gives the output `{h,m}`, where `h` is the held symbol. `l` becomes the new held symbol, so no symbol is lost.
- R6: When ORD is in both lanes of a hunted word, the MS-lane occurrence decides. In unshifted operation this means a pad is inserted.
- R7: `aligned` stays 1 until a new rising edge of `trig` or reset. A rising edge with no decision in the same cycle drives `aligned` to 0 on the next cycle.
- R8: Words with `in_valid` low are neither examined nor passed. They leave the held symbol and the lane offset unchanged.
- R9: A hunt started in shifted operation treats ORD in the input MS lane as already ordered and keeps the offset. ORD found only in the input LS lane returns the block to unshifted operation: that word comes out unchanged and the held symbol is discarded.
- R10: Before a trigger, and while a hunt has not yet matched, words pass through with the current lane offset.
- R11: `out_valid` equals `in_valid` delayed by exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Datapath clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_word | input | 32 | Deserialized word, MS lane in [31:16], LS lane in [15:0] |
| in_valid | input | 1 | Qualifies `in_word` |
| trig | input | 1 | Hunt request, acted on at its rising edge |
| order_sym | input | 16 | Programmed ordering symbol (ORD) |
| pad_sym | input | 16 | Programmed pad symbol (PAD) |
| out_word | output | 32 | Realigned word |
| out_valid | output | 1 | Qualifies `out_word` |
| aligned | output | 1 | Ordering decision has been made since the last trigger edge |

## Verification
Two functions can land in the same cycle. One is a trigger rising edge, which clears the flag. The other is a pattern match in the same word, which sets it. The bench forces this with directed words that carry ORD on the cycle of the edge, in both shifted and unshifted operation. Random runs also raise `trig` while ORD-heavy words arrive. The bench counts the match as winning: `aligned` must read 1 on the next cycle, with the output word that the decision implies. A second pairing is a shifted hunt whose match drops the held symbol. That case is checked against the bench model word for word.

// File: rtl/boa_pkg.sv
package boa_pkg;
  typedef enum logic [1:0] {
    DEC_NONE    = 2'd0,
    DEC_KEEP    = 2'd1,
    DEC_PAD     = 2'd2,
    DEC_UNSHIFT = 2'd3
  } boa_dec_e;
endpackage

// File: rtl/boa_rise.sv
module boa_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;

  // R2: a held level yields one pulse only
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/boa_lane_match.sv
module boa_lane_match #(
  parameter int LANE_W  = 16,
  parameter int N_LANES = 2
) (
  input  logic [N_LANES*LANE_W-1:0] word,
  input  logic [LANE_W-1:0]         sym,
  output logic [N_LANES-1:0]        hit
);
  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    assign hit[g] = (word[g*LANE_W +: LANE_W] == sym);
  end
endmodule

// File: rtl/boa_decide.sv
module boa_decide
  import boa_pkg::*;
(
  input  logic       hunting,
  input  logic       valid,
  input  logic       shifted,
  input  logic [1:0] hit,
  output boa_dec_e   dec
);
  always_comb begin
    dec = DEC_NONE;
    if (hunting && valid) begin
      if (!shifted) begin
        if (hit[1])      dec = DEC_PAD;
        else if (hit[0]) dec = DEC_KEEP;
      end else begin
        if (hit[1])      dec = DEC_KEEP;
        else if (hit[0]) dec = DEC_UNSHIFT;
      end
    end
  end
endmodule

// File: rtl/boa_steer.sv
module boa_steer
  import boa_pkg::*;
#(
  parameter int LANE_W = 16
) (
  input  logic                shifted,
  input  logic [LANE_W-1:0]   held,
  input  logic [2*LANE_W-1:0] in_word,
  input  logic [LANE_W-1:0]   pad_sym,
  input  boa_dec_e            dec,
  output logic [2*LANE_W-1:0] nxt_word,
  output logic [LANE_W-1:0]   nxt_held,
  output logic                nxt_shifted
);
  localparam int W = 2 * LANE_W;
  logic [LANE_W-1:0] ms_sym, ls_sym;

  assign ms_sym = in_word[W-1:LANE_W];
  assign ls_sym = in_word[LANE_W-1:0];

  always_comb begin
    nxt_word    = in_word;
    nxt_held    = held;
    nxt_shifted = shifted;
    unique case (dec)
      DEC_PAD: begin
        nxt_word    = {pad_sym, ms_sym};
        nxt_held    = ls_sym;
        nxt_shifted = 1'b1;
      end
      DEC_UNSHIFT: begin
        nxt_word    = in_word;
        nxt_shifted = 1'b0;
      end
      default: begin
        if (shifted) begin
          nxt_word = {held, ms_sym};
          nxt_held = ls_sym;
        end
      end
    endcase
  end
endmodule

// File: rtl/byte_order_aligner.sv
module byte_order_aligner
  import boa_pkg::*;
#(
  parameter int LANE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*LANE_W-1:0] in_word,
  input  logic                in_valid,
  input  logic                trig,
  input  logic [LANE_W-1:0]   order_sym,
  input  logic [LANE_W-1:0]   pad_sym,
  output logic [2*LANE_W-1:0] out_word,
  output logic                out_valid,
  output logic                aligned
);
  localparam int N_LANES = 2;
  localparam int W       = N_LANES * LANE_W;

  logic              rise;
  logic [1:0]        hit;
  boa_dec_e          dec;
  logic              hunting;
  logic              decided;

  logic              shifted_q, shifted_d;
  logic [LANE_W-1:0] held_q, held_d;
  logic              armed_q, armed_d;
  logic              aligned_q, aligned_d;
  logic [W-1:0]      word_q, word_d;
  logic              valid_q;

  boa_rise u_rise (.clk(clk), .rst_n(rst_n), .lvl(trig), .rise(rise));

  boa_lane_match #(.LANE_W(LANE_W), .N_LANES(N_LANES)) u_match (
    .word(in_word), .sym(order_sym), .hit(hit));

  assign hunting = rise | armed_q;

  boa_decide u_decide (
    .hunting(hunting), .valid(in_valid), .shifted(shifted_q),
    .hit(hit), .dec(dec));

  boa_steer #(.LANE_W(LANE_W)) u_steer (
    .shifted(shifted_q), .held(held_q), .in_word(in_word),
    .pad_sym(pad_sym), .dec(dec), .nxt_word(word_d),
    .nxt_held(held_d), .nxt_shifted(shifted_d));

  assign decided = (dec != DEC_NONE);

  // next state of the hunt control
  always_comb begin
    armed_d   = armed_q;
    aligned_d = aligned_q;
    if (decided) begin
      armed_d   = 1'b0;
      aligned_d = 1'b1;
    end else if (rise) begin
      armed_d   = 1'b1;
      aligned_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      aligned_q <= 1'b0;
      valid_q   <= 1'b0;
    end else begin
      armed_q   <= armed_d;
      aligned_q <= aligned_d;
      valid_q   <= in_valid;
    end
  end

  // datapath registers, enabled by input valid
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shifted_q <= 1'b0;
      held_q    <= '0;
      word_q    <= '0;
    end else if (in_valid) begin
      shifted_q <= shifted_d;
      held_q    <= held_d;
      word_q    <= word_d;
    end
  end

  assign out_word  = word_q;
  assign out_valid = valid_q;
  assign aligned   = aligned_q;

  // R11
  a_r11_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_valid == $past(in_valid)));

  // R7
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (aligned && !rise) |=> aligned);

  a_r7_edge_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !in_valid) |=> !aligned);

  // R8
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(held_q) && $stable(shifted_q)));

  // R3
  a_r3_pad_out: assert property (@(posedge clk) disable iff (!rst_n)
    (hunting && in_valid && !shifted_q && hit[1]) |=>
      (out_word == {$past(pad_sym), $past(in_word[W-1:LANE_W])}) && shifted_q && aligned);

  // R4
  a_r4_keep_out: assert property (@(posedge clk) disable iff (!rst_n)
    (hunting && in_valid && !shifted_q && hit == 2'b01) |=>
      (out_word == $past(in_word)) && !shifted_q && aligned);

  // R6
  a_r6_ms_first: assert property (@(posedge clk) disable iff (!rst_n)
    (hunting && in_valid && !shifted_q && hit == 2'b11) |=> shifted_q);

  // R9
  a_r9_unshift: assert property (@(posedge clk) disable iff (!rst_n)
    (hunting && in_valid && shifted_q && hit == 2'b01) |=>
      (out_word == $past(in_word)) && !shifted_q);
endmodule

// File: tb/byte_order_aligner_test.sv
`timescale 1ns/1ps
module byte_order_aligner_test;
  localparam logic [15:0] ORD = 16'h5A3C;
  localparam logic [15:0] PAD = 16'hC0DE;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] in_word;
  logic        in_valid;
  logic        trig;
  logic [31:0] out_word;
  logic        out_valid;
  logic        aligned;

  always #5 clk = ~clk;

  byte_order_aligner uut (
    .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_valid(in_valid),
    .trig(trig), .order_sym(ORD), .pad_sym(PAD),
    .out_word(out_word), .out_valid(out_valid), .aligned(aligned));

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference model state
  bit          m_off, m_armed, m_aligned, m_trq;
  logic [15:0] m_held;
  logic [31:0] e_word;
  bit          e_valid, e_aligned;
  string       e_tag;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_off = 0; m_armed = 0; m_aligned = 0; m_trq = 0; m_held = '0;
  endtask

  task automatic model(bit v, logic [31:0] w, bit t);
    bit rise, hunt;
    int dec;
    logic [15:0] ms, ls;
    ms = w[31:16]; ls = w[15:0];
    rise = t && !m_trq;
    m_trq = t;
    hunt = rise || m_armed;
    dec = 0;
    e_tag = m_off ? "R5" : "R10";
    if (hunt && v) begin
      if (!m_off) begin
        if (ms == ORD) begin dec = 2; e_tag = (ls == ORD) ? "R6" : "R3"; end
        else if (ls == ORD) begin dec = 1; e_tag = "R4"; end
      end else begin
        if (ms == ORD) begin dec = 1; e_tag = "R9"; end
        else if (ls == ORD) begin dec = 3; e_tag = "R9"; end
      end
    end
    if (dec != 0) begin m_armed = 0; m_aligned = 1; end
    else if (rise) begin m_armed = 1; m_aligned = 0; e_tag = "R7"; end
    if (v) begin
      case (dec)
        2: begin e_word = {PAD, ms}; m_held = ls; m_off = 1; end
        3: begin e_word = w; m_off = 0; end
        default: begin
          if (m_off) begin e_word = {m_held, ms}; m_held = ls; end
          else e_word = w;
        end
      endcase
    end
    e_valid = v;
    e_aligned = m_aligned;
  endtask

  // drive at a falling edge, compare at the next falling edge
  task automatic step(bit v, logic [31:0] w, bit t);
    in_valid = v; in_word = w; trig = t;
    model(v, w, t);
    @(posedge clk);
    @(negedge clk);
    chk(v ? "R11 out_valid" : "R8 out_valid", {31'd0, out_valid}, {31'd0, e_valid});
    chk({e_tag, " aligned"}, {31'd0, aligned}, {31'd0, e_aligned});
    if (e_valid) chk({e_tag, " out_word"}, out_word, e_word);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 0; in_word = '0; trig = 0;
    model_reset();
    repeat (2) @(negedge clk);
    chk("R1 out_valid in reset", {31'd0, out_valid}, 32'd0);
    chk("R1 aligned in reset", {31'd0, aligned}, 32'd0);
    rst_n = 1'b1;
  endtask

  function automatic logic [15:0] rnd_sym();
    return ($urandom_range(0, 9) < 3) ? ORD : 16'($urandom);
  endfunction

  initial begin
    void'($urandom(32'd2718));
    @(negedge clk);
    do_reset();

    step(1, {16'h0A01, 16'h0B02}, 0);
    chk("R1 unshifted after reset", out_word, {16'h0A01, 16'h0B02});
    step(1, {ORD, 16'h0C03}, 1);
    chk("R3 pad inserted", out_word, {PAD, ORD});
    chk("R3 aligned set", {31'd0, aligned}, 32'd1);
    step(1, {16'h0D04, 16'h0E05}, 1);
    chk("R5 held composition", out_word, {16'h0C03, 16'h0D04});
    step(1, {16'h0F06, ORD}, 1);
    chk("R2 held level no rehunt", out_word, {16'h0E05, 16'h0F06});
    step(0, {16'h1111, 16'h1111}, 1);
    chk("R8 invalid not passed", {31'd0, out_valid}, 32'd0);
    step(1, {16'h1207, 16'h1308}, 1);
    chk("R8 held kept over gap", out_word, {ORD, 16'h1207});
    step(1, {16'h1409, 16'h150A}, 0);
    step(1, {16'h160B, ORD}, 1);
    chk("R9 unshift on ls match", out_word, {16'h160B, ORD});
    step(1, {16'h170C, 16'h180D}, 0);
    chk("R9 unshifted after", out_word, {16'h170C, 16'h180D});
    step(0, 32'h0, 1);
    chk("R7 edge clears flag", {31'd0, aligned}, 32'd0);
    step(1, {ORD, ORD}, 1);
    chk("R6 ms lane wins", out_word, {PAD, ORD});
    step(1, {16'h190E, 16'h1A0F}, 0);
    step(1, {ORD, 16'h1B10}, 1);
    chk("R9 ms match keeps shift", out_word, {16'h1A0F, ORD});
    chk("R7 match on edge cycle", {31'd0, aligned}, 32'd1);
    step(1, {16'h1C11, 16'h1D12}, 1);
    chk("R10 shifted passthrough", out_word, {16'h1B10, 16'h1C11});

    @(negedge clk);
    do_reset();
    step(1, {16'h1E13, ORD}, 1);
    chk("R4 ls match no pad", out_word, {16'h1E13, ORD});
    chk("R4 aligned set", {31'd0, aligned}, 32'd1);

    for (int i = 0; i < 4000; i++) begin
      bit v, t;
      v = ($urandom_range(0, 9) < 8);
      t = ($urandom_range(0, 19) < 3) ? ~trig : trig;
      step(v, {rnd_sym(), rnd_sym()}, t);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule